// File: doc/BRIEF.md
# Taken-Only Branch Target Cache

This block sits in the fetch stage of a processor front end and is looked up every cycle with the current fetch address. A hit returns, in that same cycle, the address to fetch from on the next cycle. A hit therefore means the branch is predicted taken, and a miss means fall-through. The cache holds only branches whose target never changes: unconditional branches and conditional branches with a PC-relative target. Branches that jump through a register are never installed, so fetch always predicts them not-taken.

A later predictor that uses direction history keeps the contents up to date through one update port. It installs a branch when it predicts or resolves the branch as taken. It removes a branch when it calls the branch not-taken. Since each cached target is fixed, a hit on a branch that really is taken always gives the right target.

The cache has 128 sets of two ways each, 256 entries in total. Set selection and tag checks use the word address. Each set has one recency bit that picks which way to replace.

Top module: `taken_target_cache`

## Requirements
- R1: After a synchronous active-low reset every entry is invalid. Every lookup misses, with `lk_hit`=0 and `lk_target`=0.
- R2: A lookup is combinational. It hits when a valid way of the set selected by address bits [8:2] holds a tag equal to bits [31:9]. Bits [1:0] are ignored. On a hit, `lk_target` is the stored target with bits [1:0] forced to zero. On a miss, `lk_target` is 0.
- R3: An install (`up_en`=1, `up_remove`=0) with `up_kind` 0 (unconditional) or 1 (PC-relative conditional) can be looked up from the cycle after its clock edge.
- R4: An install with `up_kind` 2 (register target) or 3 (reserved) is dropped. Those addresses keep missing and existing entries are unchanged.
- R5: A remove (`up_enable`=1 is written `up_en`=1, with `up_remove`=1) invalidates the way that matches `up_addr` from the next cycle, whatever `up_kind` is. A remove of an address that is not present changes nothing.
- R6: An install for an address already present rewrites that way's target in place. The other way of the set keeps its entry.
- R7: An install for a new address fills an invalid way of the set first, way 0 before way 1, even when the recency bit points at a valid way.
- R8: When both ways are valid, a new install replaces the least recently used way. Every lookup hit and every install marks its way as most recently used.
- R9: Two addresses that share a set index live side by side in the two ways. Sets with different indices are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_addr | input | 32 | Current fetch address |
| lk_hit | output | 1 | Lookup hit, meaning predicted taken |
| lk_target | output | 32 | Next fetch address on a hit, 0 on a miss |
| up_en | input | 1 | Update request this cycle |
| up_remove | input | 1 | 1 = remove, 0 = install |
| up_kind | input | 2 | Branch class: 0 unconditional, 1 PC-relative conditional, 2 register target, 3 reserved |
| up_addr | input | 32 | Branch instruction address |
| up_target | input | 32 | Branch target address (bits [1:0] not stored) |

## Verification
A lookup result depends only on `lk_addr` and the stored state, so it is valid in the same cycle the address is applied. The bench drives addresses at the falling edge and samples one nanosecond later, before the next rising edge. Installs and removes take effect at the rising edge that sees them, so the bench checks them with a lookup in a later cycle. Each lookup hit also updates the recency bit at the following rising edge. Between scenarios the bench holds the lookup address on a set that is never written, which keeps the recency state predictable and lets the eviction order be worked out by hand.

// File: rtl/btc_pkg.sv
// Shared definitions for the taken-only branch target cache.
// Assumes two ways per set, so a single recency bit per set is enough.
package btc_pkg;
    localparam int unsigned WAYS    = 2;
    localparam int unsigned KIND_W  = 2;
    localparam int unsigned WORD_LSB = 2;

    typedef enum logic [KIND_W-1:0] {
        K_UNCOND  = 2'd0,
        K_RELCOND = 2'd1,
        K_REGTGT  = 2'd2,
        K_RSVD    = 2'd3
    } br_kind_e;

    // Only fixed-target branch classes may be installed.
    function automatic logic kind_cacheable(input logic [KIND_W-1:0] k);
        return (br_kind_e'(k) == K_UNCOND) || (br_kind_e'(k) == K_RELCOND);
    endfunction
endpackage

// File: rtl/btc_match.sv
// Tag comparator across all ways of one set.
// Produces one hit bit per way; assumes the caller supplies the selected set.
module btc_match
    import btc_pkg::*;
#(
    parameter int unsigned TAG_W = 23
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag,
    output logic [WAYS-1:0]            hit
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // Per-way compare, qualified by the valid bit.
        assign hit[w] = valid[w] && (tags[w] == tag);
    end
endmodule

// File: rtl/btc_victim.sv
// Way selection for an install.
// Order: an already matching way, then the first invalid way, then the LRU way.
// Assumes at most one way matches.
module btc_victim
    import btc_pkg::*;
(
    input  logic [WAYS-1:0] valid,
    input  logic [WAYS-1:0] match,
    input  logic            lru,
    output logic            way
);
    // Pick the way that an install writes.
    always_comb begin
        if (|match)         way = match[1];
        else if (!valid[0]) way = 1'b0;
        else if (!valid[1]) way = 1'b1;
        else                way = lru;
    end
endmodule

// File: rtl/btc_array.sv
// Entry storage: valid, tag and word target per way, plus one recency bit per set.
// Port A serves lookup, port B serves update. The recency bit names the victim way.
// Assumes a write and a clear never happen in the same cycle.
module btc_array
    import btc_pkg::*;
#(
    parameter int unsigned SETS  = 128,
    parameter int unsigned TAG_W = 23,
    parameter int unsigned TGT_W = 30,
    parameter int unsigned IDX_W = $clog2(SETS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           a_idx,
    output logic [WAYS-1:0]            a_valid,
    output logic [WAYS-1:0][TAG_W-1:0] a_tag,
    output logic [WAYS-1:0][TGT_W-1:0] a_tgt,
    input  logic [IDX_W-1:0]           b_idx,
    output logic [WAYS-1:0]            b_valid,
    output logic [WAYS-1:0][TAG_W-1:0] b_tag,
    output logic                       b_lru,
    input  logic                       touch_en,
    input  logic [IDX_W-1:0]           touch_idx,
    input  logic                       touch_way,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic                       wr_way,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic [TGT_W-1:0]           wr_tgt,
    input  logic                       clr_en,
    input  logic [IDX_W-1:0]           clr_idx,
    input  logic                       clr_way
);
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0][TGT_W-1:0] tgt_q   [SETS];
    logic [SETS-1:0]            lru_q;

    assign a_valid = valid_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_tgt   = tgt_q[a_idx];
    assign b_valid = valid_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_lru   = lru_q[b_idx];

    // Valid bits and recency: reset, hit touch, install, remove.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
            lru_q <= '0;
        end else begin
            if (touch_en) lru_q[touch_idx] <= ~touch_way;
            if (wr_en) begin
                valid_q[wr_idx][wr_way] <= 1'b1;
                lru_q[wr_idx]           <= ~wr_way;
            end
            if (clr_en) valid_q[clr_idx][clr_way] <= 1'b0;
        end
    end

    // Tag and target payload, written only on install.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][wr_way] <= wr_tag;
            tgt_q[wr_idx][wr_way] <= wr_tgt;
        end
    end

    // R3: an installed way is valid with the written tag on the next cycle
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)][$past(wr_way)] &&
                   tag_q[$past(wr_idx)][$past(wr_way)] == $past(wr_tag)));

    // R5: a removed way is invalid on the next cycle
    p_clear_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !valid_q[$past(clr_idx)][$past(clr_way)]);

    // R8: after an install the other way becomes the victim
    p_lru_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lru_q[$past(wr_idx)] != $past(wr_way)));
endmodule

// File: rtl/taken_target_cache.sv
// Taken-only branch target cache for the fetch stage.
// Lookup is combinational on the fetch address. Update installs or removes one
// branch per cycle and is visible from the next cycle. Register-target branch
// classes are never installed. Assumes SETS is a power of two.
module taken_target_cache
    import btc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SETS   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              up_en,
    input  logic              up_remove,
    input  logic [KIND_W-1:0] up_kind,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [ADDR_W-1:0] up_target
);
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned TAG_W = ADDR_W - IDX_W - WORD_LSB;
    localparam int unsigned TGT_W = ADDR_W - WORD_LSB;

    logic [IDX_W-1:0]           lk_idx, up_idx;
    logic [TAG_W-1:0]           lk_tag, up_tag;
    logic [WAYS-1:0]            a_valid, b_valid, lk_match, up_match;
    logic [WAYS-1:0][TAG_W-1:0] a_tag, b_tag;
    logic [WAYS-1:0][TGT_W-1:0] a_tgt;
    logic                       b_lru, lk_way, ins_way, install_go, remove_go;

    assign lk_idx = lk_addr[WORD_LSB +: IDX_W];
    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
    assign up_idx = up_addr[WORD_LSB +: IDX_W];
    assign up_tag = up_addr[ADDR_W-1 -: TAG_W];

    btc_array #(.SETS(SETS), .TAG_W(TAG_W), .TGT_W(TGT_W), .IDX_W(IDX_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_idx    (lk_idx),
        .a_valid  (a_valid),
        .a_tag    (a_tag),
        .a_tgt    (a_tgt),
        .b_idx    (up_idx),
        .b_valid  (b_valid),
        .b_tag    (b_tag),
        .b_lru    (b_lru),
        .touch_en (lk_hit),
        .touch_idx(lk_idx),
        .touch_way(lk_way),
        .wr_en    (install_go),
        .wr_idx   (up_idx),
        .wr_way   (ins_way),
        .wr_tag   (up_tag),
        .wr_tgt   (up_target[ADDR_W-1:WORD_LSB]),
        .clr_en   (remove_go),
        .clr_idx  (up_idx),
        .clr_way  (up_match[1])
    );

    btc_match #(.TAG_W(TAG_W)) u_lk_match (
        .valid(a_valid), .tags(a_tag), .tag(lk_tag), .hit(lk_match)
    );

    btc_match #(.TAG_W(TAG_W)) u_up_match (
        .valid(b_valid), .tags(b_tag), .tag(up_tag), .hit(up_match)
    );

    btc_victim u_victim (
        .valid(b_valid), .match(up_match), .lru(b_lru), .way(ins_way)
    );

    // Lookup result: hit flag and aligned target, zero on a miss.
    always_comb begin
        lk_hit    = |lk_match;
        lk_way    = lk_match[1];
        lk_target = lk_hit ? {a_tgt[lk_way], {WORD_LSB{1'b0}}} : '0;
    end

    // Update decode: install only cacheable classes, remove only when present.
    always_comb begin
        install_go = rst_n && up_en && !up_remove && kind_cacheable(up_kind);
        remove_go  = rst_n && up_en && up_remove && (|up_match);
    end

    // R6: in-place rewrite means no address ever sits in two ways
    p_no_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R2: a miss never presents a target
    p_miss_target_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_target == '0));

    // R4: a non-cacheable install leaves that set's contents untouched
    p_regtgt_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && !up_remove && up_kind[1]) |=>
            ($stable(u_array.valid_q[$past(up_idx)]) && $stable(u_array.tag_q[$past(up_idx)])));

    // R1: the cycle after reset release nothing hits
    p_reset_empty_r1: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> !lk_hit);
endmodule

// File: tb/sim_taken_target_cache.sv
`timescale 1ns/1ps
module sim_taken_target_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_addr;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic        up_en = 1'b0;
    logic        up_remove = 1'b0;
    logic [1:0]  up_kind = 2'd0;
    logic [31:0] up_addr = '0;
    logic [31:0] up_target = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    taken_target_cache u0 (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit),
        .lk_target(lk_target), .up_en(up_en), .up_remove(up_remove),
        .up_kind(up_kind), .up_addr(up_addr), .up_target(up_target)
    );

    // Address from set index (bits [8:2]) and tag (bits [31:9]).
    function automatic logic [31:0] mk(input int set, input int tag);
        logic [6:0]  s = set[6:0];
        logic [22:0] t = tag[22:0];
        return {t, s, 2'b00};
    endfunction

    localparam logic [31:0] PARK = {23'h7FFFFF, 7'd100, 2'b00};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Lookup and check; the hit touches recency at the following edge.
    task automatic look(input string req, input logic [31:0] a, input logic eh, input logic [31:0] et);
        @(negedge clk);
        lk_addr = a;
        #1;
        chk({req, " hit"}, {31'd0, lk_hit}, {31'd0, eh});
        chk({req, " target"}, lk_target, et);
        @(negedge clk);
        lk_addr = PARK;
    endtask

    task automatic upd(input logic rem, input logic [1:0] kind, input logic [31:0] a, input logic [31:0] t);
        @(negedge clk);
        up_en = 1'b1; up_remove = rem; up_kind = kind; up_addr = a; up_target = t;
        @(negedge clk);
        up_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 hit in reset", {31'd0, lk_hit}, 32'd0);
        look("R1 empty a", mk(5, 1), 1'b0, 32'h0);
        look("R1 empty b", mk(0, 0), 1'b0, 32'h0);
    endtask

    task automatic t_install();
        upd(1'b0, 2'd0, mk(5, 1), 32'h0000_1000);
        look("R3 installed", mk(5, 1), 1'b1, 32'h0000_1000);
        look("R2 low bits ignored", mk(5, 1) | 32'h3, 1'b1, 32'h0000_1000);
        look("R2 other tag misses", mk(5, 9), 1'b0, 32'h0);
        upd(1'b0, 2'd1, mk(7, 1), 32'h0000_2003);
        look("R3 relcond target aligned R2", mk(7, 1), 1'b1, 32'h0000_2000);
    endtask

    task automatic t_regtgt();
        upd(1'b0, 2'd2, mk(5, 8), 32'h0000_3000);
        look("R4 regtgt absent", mk(5, 8), 1'b0, 32'h0);
        upd(1'b0, 2'd3, mk(5, 1), 32'h0000_3400);
        look("R4 reserved left A intact", mk(5, 1), 1'b1, 32'h0000_1000);
    endtask

    task automatic t_rewrite();
        upd(1'b0, 2'd0, mk(5, 1), 32'h0000_1100);
        look("R6 rewritten", mk(5, 1), 1'b1, 32'h0000_1100);
        upd(1'b0, 2'd0, mk(5, 2), 32'h0000_1200);
        look("R9 A kept", mk(5, 1), 1'b1, 32'h0000_1100);
        look("R9 C coexists", mk(5, 2), 1'b1, 32'h0000_1200);
    endtask

    task automatic t_lru();
        look("R8 touch A", mk(5, 1), 1'b1, 32'h0000_1100);
        upd(1'b0, 2'd0, mk(5, 3), 32'h0000_1300);
        look("R8 A survives", mk(5, 1), 1'b1, 32'h0000_1100);
        look("R8 C evicted", mk(5, 2), 1'b0, 32'h0);
        look("R8 D present", mk(5, 3), 1'b1, 32'h0000_1300);
        upd(1'b0, 2'd0, mk(5, 4), 32'h0000_1400);
        look("R8 A evicted", mk(5, 1), 1'b0, 32'h0);
        look("R8 D kept", mk(5, 3), 1'b1, 32'h0000_1300);
        look("R8 E present", mk(5, 4), 1'b1, 32'h0000_1400);
    endtask

    task automatic t_remove();
        upd(1'b1, 2'd2, mk(5, 3), 32'h0);
        look("R5 D removed", mk(5, 3), 1'b0, 32'h0);
        look("R5 E kept", mk(5, 4), 1'b1, 32'h0000_1400);
        upd(1'b1, 2'd0, mk(5, 6), 32'h0);
        look("R5 absent remove no effect", mk(5, 4), 1'b1, 32'h0000_1400);
    endtask

    task automatic t_invalid_first();
        upd(1'b0, 2'd0, mk(9, 1), 32'h0000_5100);
        upd(1'b0, 2'd0, mk(9, 2), 32'h0000_5200);
        upd(1'b1, 2'd0, mk(9, 2), 32'h0);
        upd(1'b0, 2'd1, mk(9, 3), 32'h0000_5300);
        look("R7 P kept", mk(9, 1), 1'b1, 32'h0000_5100);
        look("R7 R filled free way", mk(9, 3), 1'b1, 32'h0000_5300);
    endtask

    task automatic t_sets();
        upd(1'b0, 2'd0, mk(0, 5), 32'h0000_6000);
        upd(1'b0, 2'd0, mk(127, 5), 32'h0000_7000);
        look("R9 set 0", mk(0, 5), 1'b1, 32'h0000_6000);
        look("R9 set 127", mk(127, 5), 1'b1, 32'h0000_7000);
        look("R9 set 1 empty", mk(1, 5), 1'b0, 32'h0);
    endtask

    initial begin
        lk_addr = PARK;
        repeat (4) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_install();
        t_regtgt();
        t_rewrite();
        t_lru();
        t_remove();
        t_invalid_first();
        t_sets();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule